// File: doc/BRIEF.md
# UART Register Front End with Prioritised Interrupt

This block is the software-visible side of a 16450-style serial port. A simple word-addressed bus carries reads and writes into eight registers spaced four bytes apart. Received bytes come from a byte-wide strobe and wait in a single holding register. Bytes written by software leave on a byte-wide transmit strobe. The serial shifters, baud generation and error detection sit elsewhere. The line-control, modem-control and divisor values are stored and brought out as configuration outputs for that logic.

The block keeps the line-status flags and the modem-status flags. It resolves pending causes into one identification code with a fixed priority and drives a single level interrupt from that code. The interrupt follows the enables and the status in the same cycle, so it drops as soon as its cause is cleared. A ready output tells the receive source when another byte can be taken without overrunning the holding register.

Top module: `uart_regs_top`

## Requirements
- R1: After reset, line status reads 0x60, identification reads 0x01, the data register reads 0, the interrupt is low, `rxReady` is high and all configuration outputs are zero.
- R2: The register index is `busAddr[4:2]`: 0 data, 1 interrupt enable, 2 identification, 3 line control, 4 modem control, 5 line status, 6 modem status, 7 divisor. `busRdData` is zero when `busRdEn` is low.
- R3: A write to index 0 drives `txByte` with `busWrData[7:0]` and raises `txValid` for exactly one cycle, starting the cycle after the write.
- R4: A received byte sets data ready (line status bit 0) and drops `rxReady`. A read of index 0 returns that byte and clears data ready.
- R5: A byte that arrives while data ready is set and no data read takes place in the same cycle sets overrun (bit 1). The new byte replaces the held one and data ready stays set.
- R6: A byte that arrives in the same cycle as a data read causes no overrun. The read returns the old byte and the new byte stays held with data ready set.
- R7: Interrupt enable (bits 0 receive, 1 transmit-empty, 2 line-status, 3 modem), line control, modem control (2 bits) and divisor are write-only. They read as zero, and their written values appear on `cfgLineCtrl`, `cfgModemCtrl` and `cfgDivisor` in the next cycle.
- R8: Writes to identification, line status and modem status have no effect.
- R9: The `errIn` pulses (bit 0 parity, bit 1 framing, bit 2 break) set line status bits 2, 3 and 4. These bits and overrun stay set until reset. Bits 5 and 6 always read 1.
- R10: Modem status bits 7..4 show `modemIn` (bit 0 CTS, 1 DSR, 2 RI, 3 DCD) as registered one cycle earlier. Bits 0, 1 and 3 latch any change of CTS, DSR and DCD, and bit 2 latches a falling RI. A read of index 6 clears these delta bits.
- R11: The identification value, highest priority first: 0x06 for an error flag (bits 1–4) with line-status enable, 0x04 for data ready with receive enable, 0x02 for transmit-empty with its enable, 0x00 for any delta bit with modem enable. Otherwise it is 0x01.
- R12: `irqOut` is high exactly when the identification value is not 0x01, and it falls in the cycle after the write or read that removes its cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 5 | Byte address; bits 4:2 select the register |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe; triggers read side effects |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, combinational |
| rxValid | input | 1 | A received byte is presented |
| rxByte | input | 8 | Received byte |
| rxReady | output | 1 | Holding register is empty |
| errIn | input | 3 | Parity, framing, break event pulses |
| modemIn | input | 4 | CTS, DSR, RI, DCD line levels |
| txValid | output | 1 | One-cycle transmit strobe |
| txByte | output | 8 | Byte to transmit |
| irqOut | output | 1 | Level interrupt |
| cfgLineCtrl | output | 8 | Stored line control |
| cfgModemCtrl | output | 2 | Stored modem control |
| cfgDivisor | output | 16 | Stored divisor |

## Verification
The receive path is tried in three patterns, each with its own expected flags. A lone byte followed by a read separates plain data-ready handling. Two bytes with no read between them separate overrun. A byte that lands in the same cycle as a read separates the consume-then-refill case from a true overrun. Interrupt causes are switched on one at a time and then stacked, which shows that each cause is encoded and that the higher cause wins. Modem lines are toggled with rising and falling RI, which tells the trailing-edge rule apart from the plain change rule. Back-to-back data writes with junk in the upper bits check the transmit strobe width and the byte truncation.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;
  localparam int DATA_W = 32;
  localparam int DIV_W  = 16;

  typedef enum logic [2:0] {
    IDX_DATA  = 3'd0,
    IDX_IEN   = 3'd1,
    IDX_IID   = 3'd2,
    IDX_LCTL  = 3'd3,
    IDX_MCTL  = 3'd4,
    IDX_LSTAT = 3'd5,
    IDX_MSTAT = 3'd6,
    IDX_DIV   = 3'd7
  } regIdx_t;

  localparam logic [2:0] ID_LINE = 3'b110;
  localparam logic [2:0] ID_RX   = 3'b100;
  localparam logic [2:0] ID_TX   = 3'b010;
  localparam logic [2:0] ID_MDM  = 3'b000;
  localparam logic [2:0] ID_NONE = 3'b001;

  typedef struct packed {
    logic txPush;
    logic ienWr;
    logic lctlWr;
    logic mctlWr;
    logic divWr;
    logic dataRd;
    logic mstatRd;
  } strobes_t;
endpackage

// File: rtl/uart_regs_ctrl.sv
module uart_regs_ctrl
  import uart_regs_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [3:0]        ienBits,
  input  logic [6:0]        lineStat,
  input  logic [3:0]        mdmDelta,
  output strobes_t          stb,
  output regIdx_t           rdSel,
  output logic [2:0]        intId,
  output logic              irqOut
);
  logic addrUnused;
  logic lsUnused;
  logic causeLine, causeRx, causeTx, causeMdm;

  assign addrUnused = ^{busAddr[1:0], busAddr[ADDR_W-1:5]};
  assign lsUnused   = lineStat[6];
  assign rdSel      = regIdx_t'(busAddr[4:2]);

  always_comb begin
    stb         = '0;
    stb.txPush  = busWrEn && rdSel == IDX_DATA;
    stb.ienWr   = busWrEn && rdSel == IDX_IEN;
    stb.lctlWr  = busWrEn && rdSel == IDX_LCTL;
    stb.mctlWr  = busWrEn && rdSel == IDX_MCTL;
    stb.divWr   = busWrEn && rdSel == IDX_DIV;
    stb.dataRd  = busRdEn && rdSel == IDX_DATA;
    stb.mstatRd = busRdEn && rdSel == IDX_MSTAT;
  end

  assign causeLine = ienBits[2] && (|lineStat[4:1]);
  assign causeRx   = ienBits[0] && lineStat[0];
  assign causeTx   = ienBits[1] && lineStat[5];
  assign causeMdm  = ienBits[3] && (|mdmDelta);
  assign irqOut    = causeLine | causeRx | causeTx | causeMdm;

  always_comb begin
    if (causeLine)     intId = ID_LINE;
    else if (causeRx)  intId = ID_RX;
    else if (causeTx)  intId = ID_TX;
    else if (causeMdm) intId = ID_MDM;
    else               intId = ID_NONE;
  end

  // R12
  irq_id_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (intId != ID_NONE));

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.txPush, stb.ienWr, stb.lctlWr, stb.mctlWr, stb.divWr}));
endmodule

// File: rtl/uart_regs_dp.sv
module uart_regs_dp
  import uart_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  regIdx_t           rdSel,
  input  logic [2:0]        intId,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  input  logic [2:0]        errIn,
  input  logic [3:0]        modemIn,
  output logic [3:0]        ienBits,
  output logic [6:0]        lineStat,
  output logic [3:0]        mdmDelta,
  output logic [DATA_W-1:0] busRdData,
  output logic              txValid,
  output logic [7:0]        txByte,
  output logic              rxReady,
  output logic [7:0]        cfgLineCtrl,
  output logic [1:0]        cfgModemCtrl,
  output logic [DIV_W-1:0]  cfgDivisor
);
  logic [7:0] rxHold;
  logic       dataReady;
  logic       overrun;
  logic [2:0] errSticky;
  logic [3:0] mdmQ;
  logic [3:0] mdmChg;
  logic       wdUnused;

  assign wdUnused = ^busWrData[DATA_W-1:DIV_W];

  assign mdmChg[0] = modemIn[0] ^ mdmQ[0];
  assign mdmChg[1] = modemIn[1] ^ mdmQ[1];
  assign mdmChg[2] = mdmQ[2] & ~modemIn[2];
  assign mdmChg[3] = modemIn[3] ^ mdmQ[3];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ienBits      <= '0;
      cfgLineCtrl  <= '0;
      cfgModemCtrl <= '0;
      cfgDivisor   <= '0;
      rxHold       <= '0;
      dataReady    <= 1'b0;
      overrun      <= 1'b0;
      errSticky    <= '0;
      mdmQ         <= '0;
      mdmDelta     <= '0;
      txValid      <= 1'b0;
      txByte       <= '0;
    end else begin
      txValid <= stb.txPush;
      if (stb.txPush) txByte       <= busWrData[7:0];
      if (stb.ienWr)  ienBits      <= busWrData[3:0];
      if (stb.lctlWr) cfgLineCtrl  <= busWrData[7:0];
      if (stb.mctlWr) cfgModemCtrl <= busWrData[1:0];
      if (stb.divWr)  cfgDivisor   <= busWrData[DIV_W-1:0];
      if (rxValid) begin
        rxHold    <= rxByte;
        dataReady <= 1'b1;
        if (dataReady && !stb.dataRd) overrun <= 1'b1;
      end else if (stb.dataRd) begin
        dataReady <= 1'b0;
      end
      errSticky <= errSticky | errIn;
      mdmQ      <= modemIn;
      mdmDelta  <= (stb.mstatRd ? 4'b0 : mdmDelta) | mdmChg;
    end
  end

  assign lineStat = {1'b1, 1'b1, errSticky, overrun, dataReady};
  assign rxReady  = !dataReady;

  always_comb begin
    busRdData = '0;
    if (busRdEn) begin
      unique case (rdSel)
        IDX_DATA:  busRdData[7:0] = rxHold;
        IDX_IID:   busRdData[2:0] = intId;
        IDX_LSTAT: busRdData[6:0] = lineStat;
        IDX_MSTAT: busRdData[7:0] = {mdmQ, mdmDelta};
        default:   busRdData      = '0;
      endcase
    end
  end

  // R3
  tx_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.txPush |=> (txValid && txByte == $past(busWrData[7:0])));

  // R5
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && dataReady && !stb.dataRd) |=> overrun);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overrun || (|errSticky)) |=> (overrun >= $past(overrun) &&
      (errSticky & $past(errSticky)) == $past(errSticky)));

  // R4
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dataReady && !rxValid) |=> !dataReady);

  // R11
  line_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ienBits[2] && (overrun || (|errSticky))) |-> intId == ID_LINE);
endmodule

// File: rtl/uart_regs_top.sv
module uart_regs_top
  import uart_regs_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  output logic              rxReady,
  input  logic [2:0]        errIn,
  input  logic [3:0]        modemIn,
  output logic              txValid,
  output logic [7:0]        txByte,
  output logic              irqOut,
  output logic [7:0]        cfgLineCtrl,
  output logic [1:0]        cfgModemCtrl,
  output logic [DIV_W-1:0]  cfgDivisor
);
  strobes_t   stb;
  regIdx_t    rdSel;
  logic [2:0] intId;
  logic [3:0] ienBits;
  logic [6:0] lineStat;
  logic [3:0] mdmDelta;

  uart_regs_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .ienBits(ienBits), .lineStat(lineStat),
    .mdmDelta(mdmDelta), .stb(stb), .rdSel(rdSel), .intId(intId),
    .irqOut(irqOut)
  );

  uart_regs_dp dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .rdSel(rdSel), .intId(intId),
    .busRdEn(busRdEn), .busWrData(busWrData), .rxValid(rxValid),
    .rxByte(rxByte), .errIn(errIn), .modemIn(modemIn), .ienBits(ienBits),
    .lineStat(lineStat), .mdmDelta(mdmDelta), .busRdData(busRdData),
    .txValid(txValid), .txByte(txByte), .rxReady(rxReady),
    .cfgLineCtrl(cfgLineCtrl), .cfgModemCtrl(cfgModemCtrl),
    .cfgDivisor(cfgDivisor)
  );
endmodule

// File: tb/uart_regs_top_tb.sv
module uart_regs_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        rxValid = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        rxReady;
  logic [2:0]  errIn = '0;
  logic [3:0]  modemIn = '0;
  logic        txValid;
  logic [7:0]  txByte;
  logic        irqOut;
  logic [7:0]  cfgLineCtrl;
  logic [1:0]  cfgModemCtrl;
  logic [15:0] cfgDivisor;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  logic [7:0] txQueue[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regs_top dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .rxValid(rxValid), .rxByte(rxByte), .rxReady(rxReady), .errIn(errIn),
    .modemIn(modemIn), .txValid(txValid), .txByte(txByte), .irqOut(irqOut),
    .cfgLineCtrl(cfgLineCtrl), .cfgModemCtrl(cfgModemCtrl),
    .cfgDivisor(cfgDivisor)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    if (a[4:2] == 3'd0) txQueue.push_back(d[7:0]);
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, input logic [31:0] exp, input string req);
    busAddr = a; busRdEn = 1'b1;
    #1;
    check(req, busRdData, exp);
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic rxPush(input logic [7:0] b);
    rxByte = b; rxValid = 1'b1;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  // monitor: pops expected transmit bytes as strobes appear
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && txValid) begin
        if (txQueue.size() == 0) check("R3 unexpected strobe", 32'(txByte), 32'hFFFF);
        else check("R3 tx byte", 32'(txByte), 32'(txQueue.pop_front()));
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", 32'(irqOut), 0);
    check("R1 rxReady", 32'(rxReady), 1);
    check("R1 cfg", {cfgLineCtrl, 6'b0, cfgModemCtrl, cfgDivisor}, 0);
    busRead(5'h14, 32'h60, "R1 line status");
    busRead(5'h08, 32'h01, "R1 ident");
    busRead(5'h00, 32'h00, "R1 data");
    #1 check("R2 idle read zero", busRdData, 0);

    // R7 write-only registers
    busWrite(5'h0C, 32'hFFFF_FF1B);
    busWrite(5'h10, 32'h0000_0003);
    busWrite(5'h1C, 32'hABCD_1234);
    check("R7 cfgLineCtrl", 32'(cfgLineCtrl), 32'h1B);
    check("R7 cfgModemCtrl", 32'(cfgModemCtrl), 32'h3);
    check("R7 cfgDivisor", 32'(cfgDivisor), 32'h1234);
    busRead(5'h0C, 0, "R7 lctl reads zero");
    busRead(5'h10, 0, "R7 mctl reads zero");
    busRead(5'h1C, 0, "R7 div reads zero");
    busRead(5'h04, 0, "R7 ien reads zero");

    // R8 read-only registers ignore writes
    busWrite(5'h14, 32'h0000_0000);
    busWrite(5'h08, 32'h0000_0006);
    busWrite(5'h18, 32'h0000_00FF);
    busRead(5'h14, 32'h60, "R8 line status");
    busRead(5'h08, 32'h01, "R8 ident");
    busRead(5'h18, 32'h00, "R8 modem status");

    // R3 back-to-back transmit, upper bits discarded
    busWrite(5'h00, 32'h0000_0041);
    busWrite(5'h00, 32'h1234_56A5);
    @(negedge clk);
    check("R3 strobe ends", 32'(txValid), 0);
    check("R3 queue drained", txQueue.size(), 0);

    // R11 / R12 transmit-empty cause
    busWrite(5'h04, 32'h2);
    busRead(5'h08, 32'h02, "R11 tx ident");
    check("R12 irq high", 32'(irqOut), 1);
    busWrite(5'h04, 32'h0);
    check("R12 irq dropped", 32'(irqOut), 0);

    // R4 receive and read
    rxPush(8'h5A);
    check("R4 rxReady low", 32'(rxReady), 0);
    busRead(5'h14, 32'h61, "R4 data ready");
    busWrite(5'h04, 32'h3);
    busRead(5'h08, 32'h04, "R11 rx beats tx");
    busRead(5'h00, 32'h5A, "R4 data read");
    busRead(5'h08, 32'h02, "R11 after read tx left");
    busWrite(5'h04, 32'h1);
    check("R12 irq low no cause", 32'(irqOut), 0);
    busRead(5'h14, 32'h60, "R4 data ready cleared");
    check("R4 rxReady high", 32'(rxReady), 1);

    // R6 arrival in the same cycle as a data read
    rxPush(8'h33);
    busAddr = 5'h00; busRdEn = 1'b1; rxByte = 8'h44; rxValid = 1'b1;
    #1 check("R6 old byte returned", busRdData, 32'h33);
    @(negedge clk);
    busRdEn = 1'b0; rxValid = 1'b0;
    busRead(5'h14, 32'h61, "R6 no overrun");
    busRead(5'h00, 32'h44, "R6 new byte held");

    // R10 modem status
    busWrite(5'h04, 32'h8);
    modemIn = 4'b0001;
    @(negedge clk);
    check("R12 modem irq", 32'(irqOut), 1);
    busRead(5'h08, 32'h00, "R11 modem ident");
    busRead(5'h18, 32'h11, "R10 cts delta");
    busRead(5'h18, 32'h10, "R10 delta cleared");
    check("R12 irq after clear", 32'(irqOut), 0);
    modemIn = 4'b0101;
    @(negedge clk);
    busRead(5'h18, 32'h50, "R10 rising RI no delta");
    modemIn = 4'b0001;
    @(negedge clk);
    busRead(5'h18, 32'h14, "R10 falling RI delta");
    busRead(5'h18, 32'h10, "R10 cleared again");

    // R5 overrun
    busWrite(5'h04, 32'h0);
    rxPush(8'h11);
    rxPush(8'h22);
    busRead(5'h14, 32'h63, "R5 overrun set");
    busRead(5'h00, 32'h22, "R5 new byte kept");
    busRead(5'h14, 32'h62, "R9 overrun sticky");
    busWrite(5'h04, 32'hF);
    busRead(5'h08, 32'h06, "R11 line ident highest");

    // R9 error inputs
    errIn = 3'b001;
    @(negedge clk);
    errIn = 3'b000;
    busRead(5'h14, 32'h66, "R9 parity");
    errIn = 3'b110;
    @(negedge clk);
    errIn = 3'b000;
    repeat (2) @(negedge clk);
    busRead(5'h14, 32'h7E, "R9 framing break sticky");

    // R1 reset again restores defaults
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    busRead(5'h14, 32'h60, "R1 line status after reset");
    check("R1 cfg after reset", {cfgLineCtrl, 6'b0, cfgModemCtrl, cfgDivisor}, 0);

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule